// File: doc/BRIEF.md
# Multicycle Signed/Unsigned Multiply Unit

This block multiplies two 32-bit register operands in one of four forms. Two of them produce the full 64-bit product: one treats both operands as signed, the other as unsigned. Two use only the low half-words of the operands and produce a 32-bit product. The full-width forms write the upper product word to a high result register and the lower word to a low result register. The half-width forms write only the low result register, and the high register keeps what it held before.

Each operation runs for a fixed number of cycles that depends only on its width. During that time the unit reports busy, ignores further start requests and holds its results. When the count runs out, the unit writes the product and the updated condition flags, and pulses done for one cycle. The caller supplies the current flags with the start request. The flags that the operation does not update are passed through unchanged.

The controller is a two-state machine. **IDLE** waits for a start. The transition *accept* (start with a recognised opcode) loads the cycle counter and moves to **RUN**. The transition *step* stays in RUN and decrements the counter. The transition *finish* (counter at zero) writes the results, raises done and returns to IDLE. A start that carries an unrecognised opcode is no transition at all: the machine stays in IDLE.

Top module: `mpy_unit`

## Requirements
- R1: Opcode 8'hAF multiplies the operands as signed 32-bit values. The upper 32 bits of the 64-bit product appear on res_hi and the lower 32 bits on res_lo.
- R2: Opcode 8'hAB multiplies the operands as unsigned 32-bit values and places the 64-bit product on res_hi/res_lo in the same way as R1.
- R3: Opcodes 8'hBF (signed) and 8'hBB (unsigned) multiply bits 15:0 of each operand. The operands are sign-extended for 8'hBF and zero-extended for 8'hBB. The 32-bit product goes to res_lo, and res_hi keeps its previous value.
- R4: After the clock edge that accepts a start, busy stays high for exactly 5 cycles for a 32×32 form and 3 cycles for a 16×16 form. On the next cycle busy is low, done is high, and the new results and flags are visible.
- R5: Flags are laid out as {N,Z,V,C} on bits 3:0. A 32×32 form sets N to res_lo[31] and Z to (res_lo==0). It sets V when res_hi differs from the extension of res_lo: the sign extension for 8'hAF, zero for 8'hAB. C is copied from flags_in[0] as sampled at the accepting edge.
- R6: A 16×16 form sets N and Z from res_lo as in R5 and copies V and C from flags_in as sampled at the accepting edge.
- R7: A start asserted while busy is ignored. Results, flags and latency are those of the operation already running.
- R8: A start with any opcode other than the four above is ignored: busy stays low, and results and flags are unchanged.
- R9: After reset, res_hi, res_lo and flags_out are zero, and busy and done are low.
- R10: done is high for exactly one cycle per operation. A start in the done cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin an operation |
| opcode | input | 8 | Operation select (8'hAF, 8'hAB, 8'hBF, 8'hBB) |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| flags_in | input | 4 | Current {N,Z,V,C} flags |
| res_hi | output | 32 | High result register |
| res_lo | output | 32 | Low result register |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| flags_out | output | 4 | Updated {N,Z,V,C} flags |

## Verification
The 32×32 forms deliver results and flags 6 cycles after the accepting edge, and the 16×16 forms deliver them 4 cycles after it. Busy covers the cycles in between. Every operation is checked cycle by cycle: the bench samples on the falling edge after each rising edge and expects busy high and done low for the whole latency window. It then compares products and flags in the single done cycle and confirms that done has dropped on the following cycle. For an ignored start, the bench checks the same outputs over the window in which a wrongly accepted start would have shown up.

// File: rtl/mpy_pkg.sv
package mpy_pkg;
    localparam logic [7:0] OPC_MUL_S32 = 8'hAF;
    localparam logic [7:0] OPC_MUL_U32 = 8'hAB;
    localparam logic [7:0] OPC_MUL_S16 = 8'hBF;
    localparam logic [7:0] OPC_MUL_U16 = 8'hBB;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } mpy_state_t;

    typedef struct packed {
        logic valid;
        logic wide;
        logic sgn;
    } mpy_kind_t;

    localparam int FLG_N = 3;
    localparam int FLG_Z = 2;
    localparam int FLG_V = 1;
    localparam int FLG_C = 0;
endpackage

// File: rtl/mpy_decode.sv
module mpy_decode
    import mpy_pkg::*;
(
    input  logic [7:0] opcode,
    output mpy_kind_t  kind
);
    always_comb begin
        kind = '0;
        unique case (opcode)
            OPC_MUL_S32: kind = '{valid: 1'b1, wide: 1'b1, sgn: 1'b1};
            OPC_MUL_U32: kind = '{valid: 1'b1, wide: 1'b1, sgn: 1'b0};
            OPC_MUL_S16: kind = '{valid: 1'b1, wide: 1'b0, sgn: 1'b1};
            OPC_MUL_U16: kind = '{valid: 1'b1, wide: 1'b0, sgn: 1'b0};
            default:     kind = '0;
        endcase
    end
endmodule

// File: rtl/mpy_ctrl.sv
module mpy_ctrl
    import mpy_pkg::*;
#(
    parameter int LAT_WIDE = 5,
    parameter int LAT_HALF = 3,
    localparam int LAT_MAX = (LAT_WIDE > LAT_HALF) ? LAT_WIDE : LAT_HALF,
    localparam int CNT_W   = (LAT_MAX > 2) ? $clog2(LAT_MAX) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic op_valid,
    input  logic op_wide,
    output logic busy,
    output logic done,
    output logic accept,
    output logic finish
);
    mpy_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        accept  = 1'b0;
        finish  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start && op_valid) begin
                    accept  = 1'b1;
                    state_d = ST_RUN;
                    cnt_d   = op_wide ? CNT_W'(LAT_WIDE - 1) : CNT_W'(LAT_HALF - 1);
                end
            end
            ST_RUN: begin
                if (cnt_q == '0) begin
                    finish  = 1'b1;
                    state_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) done <= 1'b0;
        else        done <= finish;
    end

    always_comb busy = (state_q == ST_RUN);

    assert_cnt_steps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_q != '0) |=> (busy && cnt_q == $past(cnt_q) - 1'b1));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));
endmodule

// File: rtl/mpy_datapath.sv
module mpy_datapath
    import mpy_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int HALF = WIDTH / 2,
    localparam int DBL  = 2 * WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             finish,
    input  mpy_kind_t        kind,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [3:0]       flags_in,
    output logic [WIDTH-1:0] res_hi,
    output logic [WIDTH-1:0] res_lo,
    output logic [3:0]       flags_out
);
    logic [WIDTH-1:0] a_q, b_q;
    logic [3:0]       fl_q;
    logic             wide_q, sgn_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q    <= '0;
            b_q    <= '0;
            fl_q   <= '0;
            wide_q <= 1'b0;
            sgn_q  <= 1'b0;
        end else if (accept) begin
            a_q    <= op_a;
            b_q    <= op_b;
            fl_q   <= flags_in;
            wide_q <= kind.wide;
            sgn_q  <= kind.sgn;
        end
    end

    logic [DBL-1:0]   ext_a, ext_b, prod_w;
    logic [WIDTH-1:0] hx_a, hx_b, prod_h;
    logic [WIDTH-1:0] new_hi, new_lo;
    logic [3:0]       new_fl;
    logic             ovf;

    always_comb begin
        ext_a  = sgn_q ? {{WIDTH{a_q[WIDTH-1]}}, a_q} : {{WIDTH{1'b0}}, a_q};
        ext_b  = sgn_q ? {{WIDTH{b_q[WIDTH-1]}}, b_q} : {{WIDTH{1'b0}}, b_q};
        prod_w = ext_a * ext_b;
        hx_a   = sgn_q ? {{(WIDTH-HALF){a_q[HALF-1]}}, a_q[HALF-1:0]}
                       : {{(WIDTH-HALF){1'b0}}, a_q[HALF-1:0]};
        hx_b   = sgn_q ? {{(WIDTH-HALF){b_q[HALF-1]}}, b_q[HALF-1:0]}
                       : {{(WIDTH-HALF){1'b0}}, b_q[HALF-1:0]};
        prod_h = hx_a * hx_b;

        new_hi = wide_q ? prod_w[DBL-1:WIDTH] : res_hi;
        new_lo = wide_q ? prod_w[WIDTH-1:0]   : prod_h;
        ovf    = sgn_q ? (new_hi != {WIDTH{new_lo[WIDTH-1]}}) : (new_hi != '0);

        new_fl        = fl_q;
        new_fl[FLG_N] = new_lo[WIDTH-1];
        new_fl[FLG_Z] = (new_lo == '0);
        if (wide_q) new_fl[FLG_V] = ovf;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_hi    <= '0;
            res_lo    <= '0;
            flags_out <= '0;
        end else if (finish) begin
            res_hi    <= new_hi;
            res_lo    <= new_lo;
            flags_out <= new_fl;
        end
    end

    assert_hi_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && !wide_q) |=> $stable(res_hi));

    assert_carry_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> (flags_out[FLG_C] == $past(fl_q[FLG_C])));
endmodule

// File: rtl/mpy_unit.sv
module mpy_unit
    import mpy_pkg::*;
#(
    parameter int WIDTH    = 32,
    parameter int LAT_WIDE = 5,
    parameter int LAT_HALF = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       opcode,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [3:0]       flags_in,
    output logic [WIDTH-1:0] res_hi,
    output logic [WIDTH-1:0] res_lo,
    output logic             busy,
    output logic             done,
    output logic [3:0]       flags_out
);
    mpy_kind_t kind;
    logic      accept, finish;

    mpy_decode u_dec (
        .opcode (opcode),
        .kind   (kind)
    );

    mpy_ctrl #(
        .LAT_WIDE (LAT_WIDE),
        .LAT_HALF (LAT_HALF)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .op_valid (kind.valid),
        .op_wide  (kind.wide),
        .busy     (busy),
        .done     (done),
        .accept   (accept),
        .finish   (finish)
    );

    mpy_datapath #(
        .WIDTH (WIDTH)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .finish    (finish),
        .kind      (kind),
        .op_a      (op_a),
        .op_b      (op_b),
        .flags_in  (flags_in),
        .res_hi    (res_hi),
        .res_lo    (res_lo),
        .flags_out (flags_out)
    );

    // Z must agree with the low result whenever a result is presented (R5, R6)
    assert_zero_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flags_out[FLG_Z] == (res_lo == '0)));
endmodule

// File: tb/tb_mpy_unit.sv
module tb_mpy_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = '0;
    logic [31:0] op_a = '0, op_b = '0;
    logic [3:0]  flags_in = '0;
    logic [31:0] res_hi, res_lo;
    logic        busy, done;
    logic [3:0]  flags_out;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    mpy_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .op_a(op_a), .op_b(op_b), .flags_in(flags_in),
        .res_hi(res_hi), .res_lo(res_lo), .busy(busy), .done(done),
        .flags_out(flags_out)
    );

    typedef struct packed {
        logic [7:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [3:0]  fl;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{8'hAF, 32'h0000_0007, 32'hFFFF_FFFD, 4'b0000},
        '{8'hAF, 32'h8000_0000, 32'h8000_0000, 4'b0001},
        '{8'hAF, 32'h0000_0000, 32'h1234_5678, 4'b1111},
        '{8'hAF, 32'h0001_0000, 32'h0000_8000, 4'b0000},
        '{8'hAB, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'b0000},
        '{8'hAB, 32'h0000_FFFF, 32'h0000_0003, 4'b0001},
        '{8'hBF, 32'hABCD_FFFE, 32'h1234_0003, 4'b0010},
        '{8'hBB, 32'hABCD_FFFE, 32'h1234_0003, 4'b0011},
        '{8'hBF, 32'h0000_8000, 32'h0000_8000, 4'b1100},
        '{8'hBB, 32'h0000_0000, 32'hFFFF_FFFF, 4'b0000},
        '{8'hAB, 32'h1234_5678, 32'h9ABC_DEF0, 4'b0100},
        '{8'hBF, 32'h7FFF_7FFF, 32'hFFFF_FFFF, 4'b0001}
    };

    logic [31:0] m_hi = '0, m_lo = '0;
    logic [3:0]  m_fl = '0;

    function automatic string req_of(input logic [7:0] op);
        case (op)
            8'hAF:   return "R1/R5";
            8'hAB:   return "R2/R5";
            default: return "R3/R6";
        endcase
    endfunction

    task automatic model(input vec_t v);
        logic [63:0] xa, xb, p;
        logic [31:0] ha, hb;
        logic        sg, wd;
        sg = (v.op == 8'hAF) || (v.op == 8'hBF);
        wd = (v.op == 8'hAF) || (v.op == 8'hAB);
        if (wd) begin
            xa = sg ? {{32{v.a[31]}}, v.a} : {32'h0, v.a};
            xb = sg ? {{32{v.b[31]}}, v.b} : {32'h0, v.b};
            p  = xa * xb;
            m_hi = p[63:32];
            m_lo = p[31:0];
            m_fl[1] = sg ? (m_hi != {32{m_lo[31]}}) : (m_hi != 32'h0);
        end else begin
            ha = sg ? {{16{v.a[15]}}, v.a[15:0]} : {16'h0, v.a[15:0]};
            hb = sg ? {{16{v.b[15]}}, v.b[15:0]} : {16'h0, v.b[15:0]};
            m_lo = ha * hb;
            m_fl[1] = v.fl[1];
        end
        m_fl[3] = m_lo[31];
        m_fl[2] = (m_lo == 32'h0);
        m_fl[0] = v.fl[0];
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Issue v at the next rising edge; on return the edge has been taken.
    task automatic issue(input vec_t v);
        @(negedge clk);
        start = 1'b1; opcode = v.op; op_a = v.a; op_b = v.b; flags_in = v.fl;
        @(posedge clk);
    endtask

    // Follows an accepted op through its latency; 'poke' drives a busy-time start (R7).
    task automatic follow(input vec_t v, input bit poke);
        int  lat;
        bit  lat_ok;
        lat = ((v.op == 8'hAF) || (v.op == 8'hAB)) ? 5 : 3;
        lat_ok = 1'b1;
        model(v);
        @(negedge clk);
        if (poke) begin
            start = 1'b1; opcode = 8'hAF; op_a = 32'hFFFF_FFFF; op_b = 32'h2; flags_in = 4'hF;
        end else begin
            start = 1'b0;
        end
        if (!(busy && !done)) lat_ok = 1'b0;
        for (int i = 1; i < lat; i++) begin
            @(posedge clk); @(negedge clk);
            if (!(busy && !done)) lat_ok = 1'b0;
        end
        start = 1'b0;
        check(lat_ok, "R4", "busy window", 128'(busy), 128'(1));
        @(posedge clk); @(negedge clk);
        check(!busy && done, "R4", "done at latency", 128'({busy, done}), 128'(2'b01));
        check(res_hi == m_hi && res_lo == m_lo, poke ? "R7" : req_of(v.op), "product",
              128'({res_hi, res_lo}), 128'({m_hi, m_lo}));
        check(flags_out == m_fl, poke ? "R7" : req_of(v.op), "flags",
              128'(flags_out), 128'(m_fl));
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(res_hi == 0 && res_lo == 0 && flags_out == 0 && !busy && !done, "R9",
              "reset state", 128'({res_hi, res_lo, flags_out, busy, done}), 128'(0));
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            issue(VECS[k]);
            follow(VECS[k], 1'b0);
            @(posedge clk); @(negedge clk);
            check(!done, "R10", "done single cycle", 128'(done), 128'(0));
        end

        // R7: start while busy is ignored
        issue('{8'hBB, 32'h0000_0102, 32'h0000_0304, 4'b1010});
        follow('{8'hBB, 32'h0000_0102, 32'h0000_0304, 4'b1010}, 1'b1);
        @(posedge clk); @(negedge clk);
        check(!busy && !done, "R7", "no late start", 128'({busy, done}), 128'(0));

        // R8: unknown opcode ignored
        @(negedge clk);
        start = 1'b1; opcode = 8'h00; op_a = 32'h5; op_b = 32'h5; flags_in = 4'hF;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        check(!busy, "R8", "no busy on bad opcode", 128'(busy), 128'(0));
        repeat (6) begin @(posedge clk); @(negedge clk); end
        check(!done && res_hi == m_hi && res_lo == m_lo && flags_out == m_fl, "R8",
              "state unchanged", 128'({done, res_hi, res_lo, flags_out}),
              128'({1'b0, m_hi, m_lo, m_fl}));

        // R10: back-to-back, second start in the done cycle
        issue('{8'hAB, 32'h0000_0010, 32'h0000_0010, 4'b0000});
        follow('{8'hAB, 32'h0000_0010, 32'h0000_0010, 4'b0000}, 1'b0);
        start = 1'b1; opcode = 8'hBF; op_a = 32'h0000_FFFF; op_b = 32'h0000_0002; flags_in = 4'b0011;
        @(posedge clk);
        follow('{8'hBF, 32'h0000_FFFF, 32'h0000_0002, 4'b0011}, 1'b0);
        check(res_hi == 32'h0, "R10", "hi kept across back-to-back", 128'(res_hi), 128'(0));

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule